// File: doc/BRIEF.md
# Bus Ready Combining Logic

This block produces the one ready decision that a bus cycle sequencer uses to end a transfer or to add a wait state. It takes two ready sources. The first is a synchronous, active-high input that meets setup to the bus clock. It is used directly in the cycle where the sequencer samples ready, with no extra stage. The second is an asynchronous input with no timing relation to the clock. It is captured on the falling clock edge and then retimed on the rising edge, which costs half a cycle before it can affect a transfer. No metastable value reaches the decision logic.

The sequencer raises a sample-slot strobe in the cycle where ready matters, which is the last transfer state or a repeated wait state. In that cycle the block raises exactly one of two outputs. The ready output ends the transfer. The wait request makes the sequencer repeat the wait state and sample again on the next clock. Outside the slot both outputs stay low. Tying the synchronous input high forces ready in every slot. Tying it low leaves the decision to the asynchronous path alone. Reset clears the synchronizer, so the asynchronous path reports not-ready until a fresh sample has passed through both edges.

Top module: `bus_ready_combiner`

## Requirements
- R1: While reset is high, and in the first cycle after reset falls, the asynchronous path reads as not-ready. With the synchronous input low and the slot strobe high, the wait request is high in those cycles, whatever the asynchronous input is.
- R2: When the slot strobe and the synchronous input are both high in a cycle, the ready output is high and the wait request is low in that same cycle, whatever the asynchronous input is.
- R3: A level on the asynchronous input is captured at a falling clock edge. It first affects the outputs in the cycle that starts at the next rising edge, and not before.
- R4: With the synchronous input low and the slot strobe high, the ready output equals the synchronized asynchronous level and the wait request is its inverse.
- R5: When the slot strobe is low, both the ready output and the wait request are low.
- R6: When the slot strobe is high, exactly one of the ready output and the wait request is high.
- R7: An asynchronous pulse that rises after a falling edge and falls before the next falling edge is never seen: it raises no ready output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the asynchronous path also uses its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| sync_rdy_i | input | 1 | Synchronous ready, active high, meets setup to the rising edge |
| async_rdy_i | input | 1 | Asynchronous ready, active high, any timing |
| sample_slot_i | input | 1 | High in the cycle where the sequencer samples ready |
| rdy_o | output | 1 | Transfer ends at the coming rising edge |
| wait_req_o | output | 1 | Insert or repeat a wait state |

## Verification
Assertions check four things on every cycle. Both outputs are silent outside the slot. Exactly one output is high inside the slot. A high synchronous input always wins. The rising-edge stage always copies the value the falling-edge stage held one cycle earlier. The bench shows what no single-cycle property can: the total half-cycle latency of the asynchronous path, the blindness to pulses that fall between two falling edges, and the cleared state of the synchronizer after reset. It drives the asynchronous input at random points before or after the falling edge and compares both outputs against an edge-by-edge behavioural model.

// File: rtl/rdy_pkg.sv
package rdy_pkg;

    // Rising-edge retiming stages after the falling-edge capture
    localparam int unsigned RISE_STAGES_DEF = 1;

    typedef struct packed {
        logic ready;
        logic wait_req;
    } rdy_decision_t;

    // Combine both ready sources inside the sampling slot
    function automatic rdy_decision_t combine_ready(
        input logic slot,
        input logic sync_rdy,
        input logic async_synced
    );
        rdy_decision_t d;
        logic eff;
        eff        = sync_rdy | async_synced;
        d.ready    = slot & eff;
        d.wait_req = slot & ~eff;
        return d;
    endfunction

endpackage

// File: rtl/rdy_async_sync.sv
module rdy_async_sync #(
    parameter int unsigned RISE_STAGES = rdy_pkg::RISE_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic synced_o
);
    localparam int unsigned LAST = RISE_STAGES - 1;

    logic             fall_q;
    logic [LAST:0]    rise_q;

    // Half-cycle capture on the falling edge
    always_ff @(negedge clk) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= async_i;
    end

    // Retiming chain on the rising edge
    generate
        for (genvar g = 0; g < RISE_STAGES; g++) begin : g_rise
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) rise_q[0] <= 1'b0;
                    else     rise_q[0] <= fall_q;
                end
            end else begin : g_more
                always_ff @(posedge clk) begin
                    if (rst) rise_q[g] <= 1'b0;
                    else     rise_q[g] <= rise_q[g-1];
                end
            end
        end
    endgenerate

    assign synced_o = rise_q[LAST];

    // R3: the rising stage always holds what the falling stage held one cycle before
    a_r3_rise_follows_fall: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> rise_q[0] == $past(fall_q));

endmodule

// File: rtl/rdy_decide.sv
module rdy_decide (
    input  logic clk,
    input  logic rst,
    input  logic slot_i,
    input  logic sync_rdy_i,
    input  logic async_synced_i,
    output rdy_pkg::rdy_decision_t dec_o
);
    import rdy_pkg::*;

    always_comb begin
        dec_o = combine_ready(slot_i, sync_rdy_i, async_synced_i);
    end

    // R5: silent outside the sampling slot
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !slot_i |-> (!dec_o.ready && !dec_o.wait_req));

    // R6: one decision per slot
    a_r6_one_decision: assert property (@(posedge clk) disable iff (rst)
        slot_i |-> $countones({dec_o.ready, dec_o.wait_req}) == 1);

    // R2: synchronous ready forces completion
    a_r2_sync_wins: assert property (@(posedge clk) disable iff (rst)
        (slot_i && sync_rdy_i) |-> dec_o.ready);

endmodule

// File: rtl/bus_ready_combiner.sv
module bus_ready_combiner #(
    parameter int unsigned RISE_STAGES = rdy_pkg::RISE_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_rdy_i,
    input  logic async_rdy_i,
    input  logic sample_slot_i,
    output logic rdy_o,
    output logic wait_req_o
);
    import rdy_pkg::*;

    logic          async_synced;
    rdy_decision_t dec;

    rdy_async_sync #(.RISE_STAGES(RISE_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_i  (async_rdy_i),
        .synced_o (async_synced)
    );

    rdy_decide u_decide (
        .clk            (clk),
        .rst            (rst),
        .slot_i         (sample_slot_i),
        .sync_rdy_i     (sync_rdy_i),
        .async_synced_i (async_synced),
        .dec_o          (dec)
    );

    assign rdy_o      = dec.ready;
    assign wait_req_o = dec.wait_req;

endmodule

// File: tb/bus_ready_combiner_bench.sv
module bus_ready_combiner_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_rdy = 1'b0;
    logic async_rdy = 1'b0;
    logic slot = 1'b0;
    logic rdy, wait_req;

    int checks = 0;
    int errors = 0;

    // behavioural model state: value seen at each falling edge, queued to the rising edge
    bit fall_seen [$];
    bit model_synced = 1'b0;
    bit rst_held = 1'b1;

    always #10 clk = ~clk;

    bus_ready_combiner u_bus_ready_combiner (
        .clk           (clk),
        .rst           (rst),
        .sync_rdy_i    (sync_rdy),
        .async_rdy_i   (async_rdy),
        .sample_slot_i (slot),
        .rdy_o         (rdy),
        .wait_req_o    (wait_req)
    );

    // One clock: drive at +5, model the falling edge at +10,
    // optional late change at +13, compare at +18.
    task automatic step(input bit r, input bit s, input bit sl, input bit a,
                        input bit late, input bit late_val, input string tag);
        bit exp_rdy, exp_wait, eff;
        @(posedge clk);
        if (fall_seen.size() > 0) model_synced = fall_seen.pop_front();
        if (rst_held) model_synced = 1'b0;
        #5;
        rst = r; sync_rdy = s; slot = sl; async_rdy = a;
        rst_held = r;
        #5;
        fall_seen.push_back(r ? 1'b0 : a);
        #3;
        if (late) async_rdy = late_val;
        #5;
        eff      = s | model_synced;
        exp_rdy  = sl & eff;
        exp_wait = sl & ~eff;
        checks++;
        if (rdy !== exp_rdy || wait_req !== exp_wait) begin
            errors++;
            $display("FAIL %s: rdy/wait actual %b%b expected %b%b", tag, rdy, wait_req, exp_rdy, exp_wait);
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset with async held high; first cycle after release still waits
        step(1, 0, 1, 1, 0, 0, "R1");
        step(1, 0, 1, 1, 0, 0, "R1");
        step(1, 0, 1, 1, 0, 0, "R1");
        step(0, 0, 1, 1, 0, 0, "R1");
        step(0, 0, 1, 1, 0, 0, "R4");
        // R5: no slot, outputs silent
        step(0, 1, 0, 1, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, "R5");
        // R2: sync wins even with async low
        step(0, 1, 1, 0, 0, 0, "R2");
        step(0, 1, 1, 0, 0, 0, "R2");
        // R3: async rise affects outputs one cycle later
        step(0, 0, 1, 0, 0, 0, "R3");
        step(0, 0, 1, 1, 0, 0, "R3");
        step(0, 0, 1, 1, 0, 0, "R3");
        // R7: pulse between falling edges is missed
        step(0, 0, 1, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 1, 1, "R7");
        step(0, 0, 1, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 0, 0, "R7");
        // R6/R4: random timing of both sources
        for (int i = 0; i < 3000; i++) begin
            step(0, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) != 0),
                 $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), "R6");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule